// File: doc/BRIEF.md
# Register File with Deferred Fault Reporting

This block is a multi-ported architectural register file for a processor that runs operations speculatively. Each register holds a data word and, beside it, a small fault-status field. The unit that produces a result writes the value and a status code in the same write. The code is zero for a clean result and nonzero when the operation faulted, for example a load that would need a page fault or a division by zero. The faulting operation still retires its write and does not trap. Its fault stays in the destination register.

The trap is raised only when a later operation reads that register with its read enable set. The exception request appears in the same cycle as the read, which is the start of the consuming operation. It carries the stored cause and the register number. A poisoned register that is overwritten, or that is never read, never raises a trap. A speculative load whose address would fault can therefore mark its destination and start no fault service. Register 0 is hardwired to zero.

Status codes: 0 clean, 1 page fault, 2 divide by zero, 3 access violation. Codes 4 to 7 are reserved but are stored and reported like any other nonzero code.

Top module: `defer_trap_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets every register to data 0 and status 0. After reset, every enabled read returns 0 and raises no exception.
- R2: A write (wrEn high, wrAddr not 0) stores wrData and wrCause at the rising edge. Later reads of that register return the stored data, whether or not the register is poisoned.
- R3: An enabled read of a register with a nonzero status drives excValid high in the same cycle, combinationally. excCause then equals the stored status and excReg equals the read address.
- R4: A write with status 0 clears earlier poison, so later reads of that register raise no exception.
- R5: A write never raises an exception by itself, even with a nonzero status. A poisoned register that is overwritten with a clean value before it is read never raises one.
- R6: While a port's read enable is low, that port raises no exception whatever the register's status. Its data output still shows the register contents.
- R7: Register 0 always reads as data 0 with status 0. Writes to it have no effect.
- R8: When a read address equals the address being written in the same cycle (and that address is not 0), the read returns the incoming wrData and wrCause (write-first bypass).
- R9: If both ports hit poisoned registers in one cycle, port A is reported and excPortB is 0. excPortB is 1 only when port B alone is reported. When excValid is 0, excCause, excReg and excPortB are 0.
- R10: Reserved codes 4 to 7 are stored and reported exactly like codes 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write register number |
| wrData | input | 32 | Write data |
| wrCause | input | 3 | Status code of the producing operation |
| rdEnA | input | 1 | Port A read enable (qualifies exceptions) |
| rdAddrA | input | 5 | Port A register number |
| rdDataA | output | 32 | Port A read data |
| rdEnB | input | 1 | Port B read enable |
| rdAddrB | input | 5 | Port B register number |
| rdDataB | output | 32 | Port B read data |
| excValid | output | 1 | Exception request for a poisoned read |
| excCause | output | 3 | Stored status of the reported register |
| excReg | output | 5 | Register number of the reported read |
| excPortB | output | 1 | 1 when the report comes from port B |

## Verification
Two functions can fall in the same cycle: a write to a register and a read of that same register, which makes the bypass decide both the data and the exception. Both read ports can also find poison at once, which makes the arbitration choose between them. The bench provokes both with random traffic whose addresses are often confined to a few low registers, so collisions are frequent. Directed cycles cover a poisoned write read back in the same cycle and poison seen on both ports at once. Each cycle, the data and exception outputs are compared with a bench model that applies the bypass and port A priority before the edge commits the write.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int CAUSE_W = 3;
  localparam int NUM_PORTS = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_OK     = 3'd0,
    CAUSE_PAGE   = 3'd1,
    CAUSE_DIVZ   = 3'd2,
    CAUSE_ACCESS = 3'd3
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 commit;  // write goes into storage
    logic [NUM_PORTS-1:0] fwd;     // per read port: take incoming write
  } strobe_t;
endpackage

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  strobe_t                             stb,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [CAUSE_W-1:0]                  wrCause,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    rdAddr,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]    rdData,
  output logic [NUM_PORTS-1:0][CAUSE_W-1:0]   rdCause
);
  logic [DATA_W-1:0]  dataMem  [NUM_REGS];
  logic [CAUSE_W-1:0] causeMem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        dataMem[i]  <= '0;
        causeMem[i] <= '0;
      end
    end else if (stb.commit) begin
      dataMem[wrAddr]  <= wrData;
      causeMem[wrAddr] <= wrCause;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      if (stb.fwd[p]) begin
        rdData[p]  = wrData;
        rdCause[p] = wrCause;
      end else if (rdAddr[p] == '0) begin
        rdData[p]  = '0;
        rdCause[p] = '0;
      end else begin
        rdData[p]  = dataMem[rdAddr[p]];
        rdCause[p] = causeMem[rdAddr[p]];
      end
    end
  end
endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                               wrEn,
  input  logic [ADDR_W-1:0]                  wrAddr,
  input  logic [NUM_PORTS-1:0]               rdEn,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   rdAddr,
  input  logic [NUM_PORTS-1:0][CAUSE_W-1:0]  rdCause,
  output strobe_t                            stb,
  output logic                               excValid,
  output logic [CAUSE_W-1:0]                 excCause,
  output logic [ADDR_W-1:0]                  excReg,
  output logic                               excPortB
);
  logic [NUM_PORTS-1:0] hit;

  always_comb begin
    stb.commit = wrEn && (wrAddr != '0);
    for (int p = 0; p < NUM_PORTS; p++) begin
      stb.fwd[p] = stb.commit && (rdAddr[p] == wrAddr);
      hit[p]     = rdEn[p] && (rdCause[p] != '0);
    end
  end

  // port A wins when both consume poison
  always_comb begin
    excValid = 1'b0;
    excCause = '0;
    excReg   = '0;
    excPortB = 1'b0;
    if (hit[0]) begin
      excValid = 1'b1;
      excCause = rdCause[0];
      excReg   = rdAddr[0];
    end else if (hit[1]) begin
      excValid = 1'b1;
      excCause = rdCause[1];
      excReg   = rdAddr[1];
      excPortB = 1'b1;
    end
  end
endmodule

// File: rtl/defer_trap_regfile.sv
module defer_trap_regfile
  import prf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [CAUSE_W-1:0] wrCause,
  input  logic               rdEnA,
  input  logic [ADDR_W-1:0]  rdAddrA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic               rdEnB,
  input  logic [ADDR_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0]  rdDataB,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic [ADDR_W-1:0]  excReg,
  output logic               excPortB
);
  strobe_t                             stb;
  logic [NUM_PORTS-1:0][ADDR_W-1:0]    portAddr;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    portData;
  logic [NUM_PORTS-1:0][CAUSE_W-1:0]   portCause;

  assign portAddr = {rdAddrB, rdAddrA};
  assign rdDataA  = portData[0];
  assign rdDataB  = portData[1];

  prf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .rdEn     ({rdEnB, rdEnA}),
    .rdAddr   (portAddr),
    .rdCause  (portCause),
    .stb      (stb),
    .excValid (excValid),
    .excCause (excCause),
    .excReg   (excReg),
    .excPortB (excPortB)
  );

  prf_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .wrCause (wrCause),
    .rdAddr  (portAddr),
    .rdData  (portData),
    .rdCause (portCause)
  );
endmodule

// File: rtl/prf_checker.sv
module prf_checker
  import prf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               wrEn,
  input logic [ADDR_W-1:0]                  wrAddr,
  input logic [DATA_W-1:0]                  wrData,
  input logic [CAUSE_W-1:0]                 wrCause,
  input logic                               rdEnA,
  input logic [ADDR_W-1:0]                  rdAddrA,
  input logic [DATA_W-1:0]                  rdDataA,
  input logic                               rdEnB,
  input logic [ADDR_W-1:0]                  rdAddrB,
  input logic [DATA_W-1:0]                  rdDataB,
  input logic                               excValid,
  input logic [CAUSE_W-1:0]                 excCause,
  input logic [ADDR_W-1:0]                  excReg,
  input logic                               excPortB,
  input logic [NUM_PORTS-1:0][CAUSE_W-1:0]  portCause
);
  // R6
  idle_noexc_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdEnA && !rdEnB) |-> !excValid);

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == '0) |-> (rdDataA == '0 && portCause[0] == '0));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0 && rdAddrA == wrAddr) |-> (rdDataA == wrData && portCause[0] == wrCause));

  // R2
  persist_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wrEn) && $past(wrAddr) != '0 && rdAddrB == $past(wrAddr)
     && !(wrEn && wrAddr == rdAddrB)) |-> (rdDataB == $past(wrData)));

  // R9
  prio_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEnA && portCause[0] != '0) |-> (excValid && !excPortB && excReg == rdAddrA && excCause == portCause[0]));

  // R3
  cause_nz_chk: assert property (@(posedge clk) disable iff (rst)
    excValid |-> (excCause != '0));

  // R9
  portb_only_chk: assert property (@(posedge clk) disable iff (rst)
    excPortB |-> (excValid && rdEnB && excReg == rdAddrB));
endmodule

bind defer_trap_regfile prf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrCause(wrCause),
  .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .rdEnB(rdEnB), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
  .excValid(excValid), .excCause(excCause), .excReg(excReg), .excPortB(excPortB),
  .portCause(portCause)
);

// File: tb/defer_trap_regfile_tb.sv
module defer_trap_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [31:0] wrData;
  logic [2:0]  wrCause;
  logic        rdEnA, rdEnB;
  logic [4:0]  rdAddrA, rdAddrB;
  logic [31:0] rdDataA, rdDataB;
  logic        excValid, excPortB;
  logic [2:0]  excCause;
  logic [4:0]  excReg;

  int checks = 0;
  int errors = 0;
  logic [31:0] mData  [32];
  logic [2:0]  mCause [32];

  always #10 clk = ~clk;  // 50 MHz

  defer_trap_regfile u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrCause(wrCause),
    .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdEnB(rdEnB), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .excValid(excValid), .excCause(excCause), .excReg(excReg), .excPortB(excPortB)
  );

  function automatic logic [31:0] expData(input logic [4:0] a);
    if (a == 5'd0) return 32'd0;
    if (wrEn && wrAddr == a) return wrData;
    return mData[a];
  endfunction

  function automatic logic [2:0] expCause(input logic [4:0] a);
    if (a == 5'd0) return 3'd0;
    if (wrEn && wrAddr == a) return wrCause;
    return mCause[a];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare all outputs against the model, then commit the write into the model
  task automatic checkAll(input string req);
    logic        hA, hB, eV, eP;
    logic [2:0]  eC;
    logic [4:0]  eR;
    hA = rdEnA && expCause(rdAddrA) != 3'd0;
    hB = rdEnB && expCause(rdAddrB) != 3'd0;
    eV = hA || hB;
    eC = hA ? expCause(rdAddrA) : (hB ? expCause(rdAddrB) : 3'd0);
    eR = hA ? rdAddrA : (hB ? rdAddrB : 5'd0);
    eP = !hA && hB;
    check(req, {rdDataA, rdDataB}, {expData(rdAddrA), expData(rdAddrB)});
    check(req, {54'd0, excValid, excCause, excReg, excPortB}, {54'd0, eV, eC, eR, eP});
    if (wrEn && wrAddr != 5'd0) begin
      mData[wrAddr]  = wrData;
      mCause[wrAddr] = wrCause;
    end
  endtask

  task automatic cyc(input logic we, input logic [4:0] wa, input logic [31:0] wd, input logic [2:0] wc,
                     input logic ea, input logic [4:0] aa, input logic eb, input logic [4:0] ab,
                     input string req);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; wrCause = wc;
    rdEnA = ea; rdAddrA = aa; rdEnB = eb; rdAddrB = ab;
    #1;
    checkAll(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; wrEn = 1'b1; wrAddr = 5'd4; wrData = 32'hDEAD; wrCause = 3'd1;
    rdEnA = 1'b0; rdEnB = 1'b0; rdAddrA = 5'd0; rdAddrB = 5'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; wrEn = 1'b0;
    for (int i = 0; i < 32; i++) begin mData[i] = 32'd0; mCause[i] = 3'd0; end

    // R1: all registers clean and zero after reset
    for (int i = 0; i < 32; i++)
      cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b1, 5'(i), 1'b1, 5'(31 - i), "R1");

    // R2, R5: poisoned write completes without trap
    cyc(1'b1, 5'd5, 32'h1111_0005, 3'd1, 1'b0, 5'd0, 1'b0, 5'd0, "R5");
    // R3: first enabled read raises the deferred page fault
    cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b1, 5'd5, 1'b0, 5'd0, "R3");
    // R4: clean overwrite clears poison
    cyc(1'b1, 5'd5, 32'h2222_0005, 3'd0, 1'b0, 5'd0, 1'b0, 5'd0, "R4");
    cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b1, 5'd5, 1'b1, 5'd5, "R4");
    // R5: poisoned then overwritten before any read
    cyc(1'b1, 5'd6, 32'h0000_0666, 3'd2, 1'b0, 5'd0, 1'b0, 5'd0, "R5");
    cyc(1'b1, 5'd6, 32'h0000_0667, 3'd0, 1'b0, 5'd0, 1'b0, 5'd0, "R5");
    cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b1, 5'd6, 1'b1, 5'd6, "R5");
    // R6: disabled reads of a poisoned register: data visible, no exception
    cyc(1'b1, 5'd7, 32'h0000_0777, 3'd3, 1'b0, 5'd0, 1'b0, 5'd0, "R6");
    cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b0, 5'd7, 1'b0, 5'd7, "R6");
    // R7: register 0 ignores writes and poison
    cyc(1'b1, 5'd0, 32'hFFFF_FFFF, 3'd2, 1'b1, 5'd0, 1'b1, 5'd0, "R7");
    cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b1, 5'd0, 1'b1, 5'd0, "R7");
    // R8: same-cycle write and read of a poisoned value
    cyc(1'b1, 5'd9, 32'h0000_0999, 3'd3, 1'b1, 5'd9, 1'b1, 5'd9, "R8");
    // R8: same-cycle clean overwrite hides the old poison
    cyc(1'b1, 5'd7, 32'h0000_0778, 3'd0, 1'b1, 5'd7, 1'b0, 5'd0, "R8");
    // R9: both ports poisoned, port A reported
    cyc(1'b1, 5'd10, 32'h0000_0AAA, 3'd2, 1'b0, 5'd0, 1'b0, 5'd0, "R9");
    cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b1, 5'd9, 1'b1, 5'd10, "R9");
    cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b0, 5'd9, 1'b1, 5'd10, "R9");
    // R10: reserved code stored and reported
    cyc(1'b1, 5'd12, 32'h0000_0CCC, 3'd5, 1'b0, 5'd0, 1'b0, 5'd0, "R10");
    cyc(1'b0, 5'd0, 32'd0, 3'd0, 1'b0, 5'd0, 1'b1, 5'd12, "R10");

    // random traffic, addresses often confined to low registers for collisions
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wa, aa, ab;
      logic [2:0] wc;
      wa = ($urandom % 2) ? 5'($urandom % 4) : 5'($urandom);
      aa = ($urandom % 2) ? 5'($urandom % 4) : 5'($urandom);
      ab = ($urandom % 2) ? 5'($urandom % 4) : 5'($urandom);
      wc = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
      cyc(1'($urandom), wa, $urandom, wc, 1'($urandom), aa, 1'($urandom), ab, "R2 R3 R8 R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule